// File: doc/BRIEF.md
# Peripheral-bus to single-port SRAM bridge

This block is an APB3 completer that turns register reads and writes into accesses on a synchronous single-port SRAM. The SRAM returns data one clock after it is enabled. The bridge drives chip-enable, write-enable, word address and write data towards the memory. It stretches reads through PREADY so that the returned word is on PRDATA when the transfer completes.

Writes finish in the first access cycle with no wait state. A read enables the SRAM during the setup cycle, waits for one access cycle and completes in the second. The byte address is turned into a word index by dropping the byte-lane bits. An index at or beyond the configured depth never reaches the memory and is answered with PSLVERR.

Top module: `apb_sram_bridge`

## Requirements
- R1: After reset and while `psel` is low, `pready`, `pslverr`, `mem_ce` are low and `prdata` is zero.
- R2: For an in-range write, `mem_ce` stays low in the setup cycle. In the first access cycle `pready`, `mem_ce` and `mem_we` are high, `mem_addr` is the word index and `mem_wdata` equals `pwdata`, so the write lands on the edge where `psel`, `penable` and `pready` are all high.
- R3: For an in-range read, the setup cycle has `mem_ce` high, `mem_we` low and `mem_addr` equal to the word index. `mem_ce` is low in both access cycles.
- R4: An in-range read holds `pready` low in the first access cycle and raises it in the second, with `prdata` equal to the latest word written to that index (or the memory's prior content).
- R5: `pslverr` is high only in a cycle where `psel`, `penable` and `pready` are all high, and is low for every in-range transfer.
- R6: A write whose word index is at or beyond DEPTH never asserts `mem_ce`, completes in its first access cycle with `pslverr` high, and leaves every SRAM word unchanged.
- R7: A read whose word index is at or beyond DEPTH never asserts `mem_ce` and completes in its first access cycle with `pslverr` high and `prdata` zero.
- R8: The word index is `paddr` shifted right by log2(DATA_W/8) (2 for the 32-bit default). The low byte-lane bits of `paddr` are ignored, so an unaligned address reaches the word that contains it.
- R9: `prdata` is zero in every cycle except the completing cycle of an in-range read.
- R10: Index DEPTH-1 (byte address 4092 by default) is in range. Index DEPTH (byte address 4096) and the top of the address space are out of range.
- R11: Transfers may follow each other with no idle cycle, a new setup directly after a completion, in any mix of reads, writes and errors.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Completer select |
| penable | input | 1 | Access phase marker |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | DATA_W | Write data |
| prdata | output | DATA_W | Read data, valid on read completion |
| pready | output | 1 | Transfer completes in this cycle |
| pslverr | output | 1 | Error response for out-of-range index |
| mem_ce | output | 1 | SRAM chip enable |
| mem_we | output | 1 | SRAM write enable (with `mem_ce`) |
| mem_addr | output | log2(DEPTH) | SRAM word index |
| mem_wdata | output | DATA_W | SRAM write data |
| mem_rdata | input | DATA_W | SRAM read data, one cycle after enable |

## Verification
The bench writes and reads back words at index zero, a middle index and the last index. This tells a wrong wait-state count or a misrouted address apart from a correct data path. Unaligned addresses show whether the byte-lane bits are dropped rather than folded into the index. Writes and reads just past the depth, and at the top of the address space, separate the error path from a silent wrap onto word zero. A later read of word zero proves that no write leaked through. A pseudo-random run of back-to-back and idle-separated transfers exercises the return of the wait-state tracking to its initial state after every kind of completion.

// File: rtl/asb_pkg.sv
package asb_pkg;

  // Read-tracking state of the access controller
  typedef enum logic {
    ACC_FIRST = 1'b0,  // next access cycle of a read is its first
    ACC_HELD  = 1'b1   // SRAM data captured, read may complete
  } acc_state_e;

  // Number of byte-lane bits dropped from the byte address
  function automatic int unsigned lane_shift(input int unsigned data_w);
    return $clog2(data_w / 8);
  endfunction

  // Width of the SRAM word index
  function automatic int unsigned index_width(input int unsigned depth);
    return (depth < 2) ? 1 : $clog2(depth);
  endfunction

endpackage

// File: rtl/asb_addr_decode.sv
module asb_addr_decode #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 1024,
  localparam int unsigned IDX_W = asb_pkg::index_width(DEPTH)
) (
  input  logic [ADDR_W-1:0] paddr,
  output logic [IDX_W-1:0]  word_idx,
  output logic              in_range
);
  localparam int unsigned SHIFT = asb_pkg::lane_shift(DATA_W);

  logic [ADDR_W-1:0] full_idx;

  // Byte address to word index; byte-lane bits fall off (R8)
  assign full_idx = paddr >> SHIFT;
  assign in_range = (full_idx < ADDR_W'(DEPTH));
  assign word_idx = full_idx[IDX_W-1:0];

endmodule

// File: rtl/asb_access_ctrl.sv
module asb_access_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic psel,
  input  logic penable,
  input  logic pwrite,
  input  logic in_range,
  output logic setup_rd,
  output logic wr_fire,
  output logic rd_capture,
  output logic rd_done,
  output logic err_done,
  output logic pready
);
  import asb_pkg::*;

  acc_state_e state_q, state_d;
  logic access;

  assign access     = psel & penable;
  assign setup_rd   = psel & ~penable & ~pwrite & in_range;
  assign wr_fire    = access & pwrite & in_range;
  assign rd_capture = access & ~pwrite & in_range & (state_q == ACC_FIRST);
  assign rd_done    = access & ~pwrite & in_range & (state_q == ACC_HELD);
  assign err_done   = access & ~in_range;
  assign pready     = wr_fire | rd_done | err_done;

  always_comb begin
    state_d = state_q;
    if (!psel)           state_d = ACC_FIRST;
    else if (rd_capture) state_d = ACC_HELD;
    else if (rd_done)    state_d = ACC_FIRST;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ACC_FIRST;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/asb_sram_drive.sv
module asb_sram_drive #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IDX_W  = 10
) (
  input  logic              setup_rd,
  input  logic              wr_fire,
  input  logic [IDX_W-1:0]  word_idx,
  input  logic [DATA_W-1:0] pwdata,
  output logic              mem_ce,
  output logic              mem_we,
  output logic [IDX_W-1:0]  mem_addr,
  output logic [DATA_W-1:0] mem_wdata
);
  // Reads are issued in setup, writes in the first access cycle
  assign mem_ce    = setup_rd | wr_fire;
  assign mem_we    = wr_fire;
  assign mem_addr  = word_idx;
  assign mem_wdata = pwdata;

endmodule

// File: rtl/asb_resp_path.sv
module asb_resp_path #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_capture,
  input  logic              rd_done,
  input  logic              err_done,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] prdata,
  output logic              pslverr
);
  logic [DATA_W-1:0] hold_q;

  // Capture SRAM output in the first access cycle of a read
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          hold_q <= '0;
    else if (rd_capture) hold_q <= mem_rdata;
  end

  assign prdata  = rd_done ? hold_q : '0;
  assign pslverr = err_done;

endmodule

// File: rtl/apb_sram_bridge.sv
module apb_sram_bridge #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 1024,
  localparam int unsigned IDX_W = asb_pkg::index_width(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              pready,
  output logic              pslverr,
  output logic              mem_ce,
  output logic              mem_we,
  output logic [IDX_W-1:0]  mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);
  // Named internal events, also observed by the checker
  logic [IDX_W-1:0] word_idx;
  logic addr_in_range;
  logic setup_rd;
  logic wr_fire;
  logic rd_capture;
  logic rd_done;
  logic err_done;

  asb_addr_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_dec (
    .paddr    (paddr),
    .word_idx (word_idx),
    .in_range (addr_in_range)
  );

  asb_access_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .psel       (psel),
    .penable    (penable),
    .pwrite     (pwrite),
    .in_range   (addr_in_range),
    .setup_rd   (setup_rd),
    .wr_fire    (wr_fire),
    .rd_capture (rd_capture),
    .rd_done    (rd_done),
    .err_done   (err_done),
    .pready     (pready)
  );

  asb_sram_drive #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_drv (
    .setup_rd  (setup_rd),
    .wr_fire   (wr_fire),
    .word_idx  (word_idx),
    .pwdata    (pwdata),
    .mem_ce    (mem_ce),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata)
  );

  asb_resp_path #(.DATA_W(DATA_W)) u_resp (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_capture (rd_capture),
    .rd_done    (rd_done),
    .err_done   (err_done),
    .mem_rdata  (mem_rdata),
    .prdata     (prdata),
    .pslverr    (pslverr)
  );

endmodule

// File: rtl/apb_sram_bridge_chk.sv
module apb_sram_bridge_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic              pready,
  input logic              pslverr,
  input logic [DATA_W-1:0] prdata,
  input logic              mem_ce,
  input logic              mem_we,
  input logic              addr_in_range
);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !psel |-> (!pready && !pslverr && !mem_ce && prdata == '0));

  assert_wr_no_wait_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && penable && pwrite && addr_in_range) |-> (pready && mem_ce && mem_we));

  assert_rd_issue_setup_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && !penable && !pwrite && addr_in_range) |-> (mem_ce && !mem_we));

  assert_rd_first_wait_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && !penable && !pwrite && addr_in_range) ##1 (psel && penable) |-> !pready);

  assert_rd_second_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && penable && !pwrite && !pready) |=> pready);

  assert_err_qualified_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pslverr |-> (psel && penable && pready));

  assert_oor_no_ce_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && !addr_in_range) |-> !mem_ce);

  assert_oor_read_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pslverr |-> (prdata == '0));

  assert_prdata_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(psel && penable && pready && !pwrite) |-> (prdata == '0));

endmodule

bind apb_sram_bridge apb_sram_bridge_chk #(.DATA_W(DATA_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .psel          (psel),
  .penable       (penable),
  .pwrite        (pwrite),
  .pready        (pready),
  .pslverr       (pslverr),
  .prdata        (prdata),
  .mem_ce        (mem_ce),
  .mem_we        (mem_we),
  .addr_in_range (addr_in_range)
);

// File: tb/tb_apb_sram_bridge.sv
module tb_apb_sram_bridge;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int DEPTH = 1024;
  localparam int IW = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [AW-1:0] paddr = '0;
  logic [DW-1:0] pwdata = '0;
  logic [DW-1:0] prdata, mem_wdata;
  logic [DW-1:0] mem_rdata = '0;
  logic pready, pslverr, mem_ce, mem_we;
  logic [IW-1:0] mem_addr;

  int tests = 0;
  int fails = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  apb_sram_bridge #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .pslverr(pslverr), .mem_ce(mem_ce), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  function automatic logic [DW-1:0] init_pat(input int idx);
    return (32'(idx) * 32'h0101_0101) ^ 32'hA5A5_0000;
  endfunction

  // SRAM model: one-cycle read latency, output held between reads
  logic [DW-1:0] sram [DEPTH];
  initial for (int i = 0; i < DEPTH; i++) sram[i] = init_pat(i);
  always @(posedge clk) begin
    if (mem_ce && mem_we) sram[mem_addr] <= mem_wdata;
    else if (mem_ce)      mem_rdata <= sram[mem_addr];
  end

  // Reference model: transaction-level memory content
  logic [DW-1:0] ref_mem [int];
  function automatic logic [DW-1:0] ref_rd(input int idx);
    return ref_mem.exists(idx) ? ref_mem[idx] : init_pat(idx);
  endfunction

  // Per-cycle expectations
  logic chk_en = 1'b0;
  string tag = "R1";
  logic e_pready = 0, e_err = 0, e_ce = 0, e_we = 0;
  logic [DW-1:0] e_rd = '0, e_wd = '0;
  logic [IW-1:0] e_addr = '0;

  task automatic expect_cyc(input string t, input logic rdy, input logic err,
                            input logic [DW-1:0] rd, input logic ce, input logic we,
                            input logic [IW-1:0] ad, input logic [DW-1:0] wd);
    tag = t; e_pready = rdy; e_err = err; e_rd = rd; e_ce = ce; e_we = we;
    e_addr = ad; e_wd = wd;
  endtask

  task automatic cmp(input string sig, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h (cycle %0d)", tag, sig, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (chk_en) begin
      cmp("pready", DW'(pready), DW'(e_pready));
      cmp("pslverr", DW'(pslverr), DW'(e_err));
      cmp("prdata", prdata, e_rd);
      cmp("mem_ce", DW'(mem_ce), DW'(e_ce));
      if (e_ce) begin
        cmp("mem_we", DW'(mem_we), DW'(e_we));
        cmp("mem_addr", DW'(mem_addr), DW'(e_addr));
        if (e_we) cmp("mem_wdata", mem_wdata, e_wd);
      end
    end
  end

  task automatic go_idle();
    psel = 0; penable = 0;
    expect_cyc("R1/R9 idle", 0, 0, '0, 0, 0, '0, '0);
  endtask

  task automatic xfer(input logic wr, input logic [AW-1:0] addr,
                      input logic [DW-1:0] wd, input logic idle_after);
    logic [AW-1:0] full;
    logic inr;
    logic [IW-1:0] ix;
    full = addr >> 2;
    inr = (full < AW'(DEPTH));
    ix = full[IW-1:0];
    // setup cycle
    psel = 1; penable = 0; pwrite = wr; paddr = addr; pwdata = wd;
    if (wr) expect_cyc(inr ? "R2 setup" : "R6 setup", 0, 0, '0, 0, 0, ix, wd);
    else    expect_cyc(inr ? "R3 setup" : "R7 setup", 0, 0, '0, inr, 0, ix, wd);
    @(posedge clk); #1;
    penable = 1;
    if (wr && inr)      expect_cyc("R2 access", 1, 0, '0, 1, 1, ix, wd);
    else if (wr)        expect_cyc("R6 access", 1, 1, '0, 0, 0, ix, wd);
    else if (!inr)      expect_cyc("R7 access", 1, 1, '0, 0, 0, ix, wd);
    else begin
      expect_cyc("R4 first wait", 0, 0, '0, 0, 0, ix, wd);
      @(posedge clk); #1;
      expect_cyc("R4 complete", 1, 0, ref_rd(int'(ix)), 0, 0, ix, wd);
    end
    @(posedge clk); #1;
    if (wr && inr) ref_mem[int'(ix)] = wd;
    if (idle_after) go_idle();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  logic [31:0] lfsr = 32'h1234_5678;

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    go_idle();
    chk_en = 1;
    repeat (2) @(posedge clk);
    #1;
    // R2, R4, R10: writes and readbacks at both ends and middle
    xfer(1, 32'd0, 32'hDEAD_BEEF, 1);
    xfer(1, 32'd20, 32'h1111_2222, 1);
    xfer(1, 32'd4092, 32'hCAFE_F00D, 1);
    xfer(0, 32'd0, '0, 1);
    xfer(0, 32'd20, '0, 1);
    xfer(0, 32'd4092, '0, 1);
    xfer(0, 32'd400, '0, 1);            // R4 untouched word
    // R8: unaligned addresses
    xfer(0, 32'd23, '0, 1);
    xfer(1, 32'd30, 32'h0BAD_CAFE, 1);
    xfer(0, 32'd28, '0, 1);
    // R6, R7, R10: beyond the depth
    xfer(1, 32'd4096, 32'hFFFF_FFFF, 1);
    xfer(0, 32'd0, '0, 1);              // R6 word zero not overwritten
    xfer(0, 32'd4104, '0, 1);
    xfer(0, 32'hFFFF_FFF0, '0, 1);
    xfer(1, 32'hFFFF_FFFC, 32'h5A5A_5A5A, 1);
    // R11: back-to-back mix
    xfer(1, 32'd100, 32'hAAAA_0001, 0);
    xfer(0, 32'd100, '0, 0);
    xfer(0, 32'd5000, '0, 0);
    xfer(1, 32'd104, 32'hAAAA_0002, 0);
    xfer(0, 32'd104, '0, 0);
    xfer(1, 32'd6000, 32'h0, 0);
    xfer(0, 32'd100, '0, 1);
    // R11: pseudo-random run
    for (int n = 0; n < 300; n++) begin
      logic [AW-1:0] a;
      lfsr = lfsr ^ (lfsr << 13);
      lfsr = lfsr ^ (lfsr >> 17);
      lfsr = lfsr ^ (lfsr << 5);
      if (lfsr[2:0] == 3'd0) a = 32'd4096 + {20'd0, lfsr[11:0]};
      else                   a = {20'd0, lfsr[27:16]};
      xfer(lfsr[8], a, lfsr ^ 32'h3C3C_C3C3, lfsr[9]);
    end
    go_idle();
    repeat (3) @(posedge clk);
    #1;
    chk_en = 0;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule